// File: doc/BRIEF.md
# Dual-Command Guarded Watchdog Timer

A watchdog that counts prescaled clock ticks and raises a one-cycle time-out pulse when its counter wraps. Software keeps it alive with two different clear commands, A and B. Only an A followed by a B, or a B followed by an A, clears the counter. A program stuck in a loop that issues the same command over and over cannot hold off the time-out.

The block keeps two flags. The time-out flag records that the counter expired. The power-down flag records that a halt request was taken. A completed pair clears both flags. A halt request clears the counter and the prescaler, sets the power-down flag and clears the time-out flag. The enable input gates counting: while it is low, the counter and the prescaler stay at zero. After reset the block counts at once if it is enabled. The counter value is brought out so that its progress can be seen.

Top module: `dual_clr_wdt`

## Requirements
- R1: While reset is asserted and right after it, the counter is 0, both flags are 0 and the pulse is 0. With enable high, counting starts on the first clock after reset is released.
- R2: While enabled, the counter goes up by one every 2^PRE_W clocks (the prescaler ratio), counted from reset, from a clear or from a halt.
- R3: While enable is low, the counter and the prescaler are held at 0 and the flags keep their values. The command sequencing still works while enable is low.
- R4: A command that differs from the stored pending command (A after B, or B after A) completes a pair. On that clock edge the counter and prescaler are cleared, both flags are cleared and the pending command is forgotten. Idle cycles between the two commands are allowed.
- R5: Repeating the same command does not clear the counter or change either flag. The command is only remembered, so A, A, B clears on the B.
- R6: A cycle with both command strobes high counts as no command. It does not change the pending command, the counter or the flags.
- R7: A halt request clears the counter and the prescaler, sets the power-down flag, clears the time-out flag and forgets any pending command. A halt takes priority over a command in the same cycle.
- R8: When the counter is at its maximum and a prescaler tick arrives, the counter wraps to 0, the time-out pulse is high for exactly one cycle and the time-out flag is set. The time-out period is 2^(PRE_W+CNT_W) clocks. A pair or halt in the same cycle takes priority, and no time-out occurs.
- R9: After a pair completes, a new pair needs two new commands: A, B, A clears only on the B and not on the last A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| clr_a_i | input | 1 | Clear command A strobe |
| clr_b_i | input | 1 | Clear command B strobe |
| halt_i | input | 1 | Halt request strobe |
| tmo_pulse_o | output | 1 | One-cycle time-out pulse |
| tmo_flag_o | output | 1 | Time-out flag |
| pdn_flag_o | output | 1 | Power-down flag |
| wdt_count_o | output | CNT_W | Current watchdog counter value |

## Verification
The hardest state to reach from the ports is a pending command that has to outlast other events: a halt between the two halves of a pair, a both-strobes cycle in the middle of a pair, or a long run of one repeated command. The stimulus builds these sequences on purpose and lets the counter run between the commands. A clear that happens wrongly then shows up as a zero count where a non-zero count was expected. A full free-running period is also allowed to elapse so that the wrap, the pulse and the time-out flag all occur. The following pair must then clear the time-out flag, and a halt must set the power-down flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_A    = 2'd1,
    CMD_B    = 2'd2
  } clr_cmd_e;
endpackage

// File: rtl/wdt_cmd_seq.sv
module wdt_cmd_seq
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic halt_i,
  output logic pair_done_o
);
  clr_cmd_e last_q, last_d;
  logic cmd_a, cmd_b;

  // both strobes in one cycle count as no command
  assign cmd_a = clr_a_i & ~clr_b_i;
  assign cmd_b = clr_b_i & ~clr_a_i;

  assign pair_done_o = ~halt_i &
                       ((cmd_a && last_q == CMD_B) || (cmd_b && last_q == CMD_A));

  always_comb begin
    last_d = last_q;
    if (halt_i || pair_done_o) last_d = CMD_NONE;
    else if (cmd_a)            last_d = CMD_A;
    else if (cmd_b)            last_d = CMD_B;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= CMD_NONE;
    else         last_q <= last_d;
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = ~clr_i & (&pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             terminal_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  assign terminal_o = tick_i & (&cnt_q);
  assign count_o    = cnt_q;
  assign pulse_o    = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= terminal_o;
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic pair_i,
  input  logic terminal_i,
  output logic tmo_o,
  output logic pdn_o
);
  logic tmo_q, pdn_q;

  assign tmo_o = tmo_q;
  assign pdn_o = pdn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q <= 1'b0;
      pdn_q <= 1'b0;
    end else if (halt_i) begin
      tmo_q <= 1'b0;
      pdn_q <= 1'b1;
    end else if (pair_i) begin
      tmo_q <= 1'b0;
      pdn_q <= 1'b0;
    end else if (terminal_i) begin
      tmo_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_clr_wdt.sv
module dual_clr_wdt #(
  parameter int PRE_W = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             halt_i,
  output logic             tmo_pulse_o,
  output logic             tmo_flag_o,
  output logic             pdn_flag_o,
  output logic [CNT_W-1:0] wdt_count_o
);
  logic pair_done, sync_clr, tick, terminal;

  // halt, completed pair and disable all zero the count chain
  assign sync_clr = halt_i | pair_done | ~en_i;

  wdt_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_a_i     (clr_a_i),
    .clr_b_i     (clr_b_i),
    .halt_i      (halt_i),
    .pair_done_o (pair_done)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sync_clr),
    .tick_o (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sync_clr),
    .tick_i     (tick),
    .count_o    (wdt_count_o),
    .terminal_o (terminal),
    .pulse_o    (tmo_pulse_o)
  );

  wdt_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_i     (halt_i),
    .pair_i     (pair_done),
    .terminal_i (terminal),
    .tmo_o      (tmo_flag_o),
    .pdn_o      (pdn_flag_o)
  );
endmodule

// File: rtl/dual_clr_wdt_chk.sv
module dual_clr_wdt_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             clr_a_i,
  input logic             clr_b_i,
  input logic             halt_i,
  input logic             tmo_pulse_o,
  input logic             tmo_flag_o,
  input logic             pdn_flag_o,
  input logic [CNT_W-1:0] wdt_count_o
);
  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_pulse_o |=> !tmo_pulse_o);

  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_pulse_o |-> (tmo_flag_o && wdt_count_o == '0));

  // R7
  halt_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (pdn_flag_o && !tmo_flag_o && wdt_count_o == '0 && !tmo_pulse_o));

  // R3
  disabled_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (wdt_count_o == '0 && !tmo_pulse_o));

  // R5
  idle_keeps_pdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && !clr_a_i && !clr_b_i) |=> $stable(pdn_flag_o));

  // R6
  both_strobes_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && clr_a_i && clr_b_i) |=> ($stable(pdn_flag_o) && (tmo_pulse_o || $stable(tmo_flag_o))));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !halt_i && !clr_a_i && !clr_b_i) |=>
      (wdt_count_o == $past(wdt_count_o) || wdt_count_o == $past(wdt_count_o) + 1'b1));
endmodule

bind dual_clr_wdt dual_clr_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .clr_a_i     (clr_a_i),
  .clr_b_i     (clr_b_i),
  .halt_i      (halt_i),
  .tmo_pulse_o (tmo_pulse_o),
  .tmo_flag_o  (tmo_flag_o),
  .pdn_flag_o  (pdn_flag_o),
  .wdt_count_o (wdt_count_o)
);

// File: tb/dual_clr_wdt_bench.sv
`timescale 1ns/1ps
module dual_clr_wdt_bench;
  localparam int PRE_W = 2;
  localparam int CNT_W = 6;
  localparam int DIV   = 1 << PRE_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic clr_a_i = 1'b0, clr_b_i = 1'b0, halt_i = 1'b0;
  logic tmo_pulse_o, tmo_flag_o, pdn_flag_o;
  logic [CNT_W-1:0] wdt_count_o;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  // reference state: pending 0=none 1=A 2=B
  int m_pre = 0, m_cnt = 0, m_to = 0, m_pdf = 0, m_pulse = 0, m_last = 0;

  always #4 clk = ~clk;

  dual_clr_wdt #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dual_clr_wdt (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .clr_a_i(clr_a_i),
    .clr_b_i(clr_b_i), .halt_i(halt_i), .tmo_pulse_o(tmo_pulse_o),
    .tmo_flag_o(tmo_flag_o), .pdn_flag_o(pdn_flag_o), .wdt_count_o(wdt_count_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(bit a, bit b, bit h, bit e);
    bit ca = a && !b;
    bit cb = b && !a;
    m_pulse = 0;
    if (h) begin
      m_pre = 0; m_cnt = 0; m_pdf = 1; m_to = 0; m_last = 0;
    end else if ((ca && m_last == 2) || (cb && m_last == 1)) begin
      m_pre = 0; m_cnt = 0; m_pdf = 0; m_to = 0; m_last = 0;
    end else begin
      if (ca) m_last = 1;
      if (cb) m_last = 2;
      if (!e) begin
        m_pre = 0; m_cnt = 0;
      end else if (m_pre == DIV - 1) begin
        m_pre = 0;
        if (m_cnt == CMAX) begin
          m_cnt = 0; m_to = 1; m_pulse = 1;
        end else m_cnt++;
      end else m_pre++;
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "count", int'(wdt_count_o), m_cnt);
    chk(tag, "tmo_flag", int'(tmo_flag_o), m_to);
    chk(tag, "pdn_flag", int'(pdn_flag_o), m_pdf);
    chk(tag, "pulse", int'(tmo_pulse_o), m_pulse);
  endtask

  task automatic step(string tag, bit a, bit b, bit h, bit e);
    clr_a_i = a; clr_b_i = b; halt_i = h; en_i = e;
    @(posedge clk);
    model(a, b, h, e);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n, bit e);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, e);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog R1..all cycles actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  initial begin
    en_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", int'(wdt_count_o), 0);
    chk("R1", "tmo_flag", int'(tmo_flag_o), 0);
    chk("R1", "pdn_flag", int'(pdn_flag_o), 0);
    chk("R1", "pulse", int'(tmo_pulse_o), 0);
    rst_ni = 1'b1;

    // R2 prescaled counting from reset
    idle("R2", 40, 1);
    chk("R2", "count after 40", int'(wdt_count_o), 10);

    // R5 AA does nothing, AAB clears
    step("R5", 1, 0, 0, 1);
    idle("R5", 6, 1);
    step("R5", 1, 0, 0, 1);
    step("R5", 1, 0, 0, 1);
    chk("R5", "count nonzero", int'(wdt_count_o != 0), 1);
    step("R5", 0, 1, 0, 1);
    chk("R5", "count after AAB", int'(wdt_count_o), 0);

    // R4 AB and BA with idles
    idle("R4", 20, 1);
    step("R4", 1, 0, 0, 1);
    idle("R4", 3, 1);
    step("R4", 0, 1, 0, 1);
    chk("R4", "count after AB", int'(wdt_count_o), 0);
    idle("R4", 17, 1);
    step("R4", 0, 1, 0, 1);
    step("R4", 0, 1, 0, 1);
    chk("R5", "count after BB", int'(wdt_count_o != 0), 1);
    step("R4", 1, 0, 0, 1);
    chk("R4", "count after BBA", int'(wdt_count_o), 0);

    // R9 A,B,A clears only once
    step("R9", 1, 0, 0, 1);
    step("R9", 0, 1, 0, 1);
    idle("R9", 12, 1);
    step("R9", 1, 0, 0, 1);
    chk("R9", "count after ABA", int'(wdt_count_o), 3);

    // R6 both strobes ignored: pending A survives, B then clears
    step("R6", 1, 1, 0, 1);
    idle("R6", 4, 1);
    step("R6", 0, 1, 0, 1);
    chk("R6", "count after A,AB,B", int'(wdt_count_o), 0);
    step("R6", 0, 1, 0, 1);
    step("R6", 1, 1, 0, 1);
    idle("R6", 8, 1);
    step("R6", 0, 1, 0, 1);
    chk("R6", "count after B,AB,B", int'(wdt_count_o != 0), 1);

    // R8 free-running time-out
    idle("R8", 270, 1);
    chk("R8", "tmo_flag", int'(tmo_flag_o), 1);
    step("R4", 1, 0, 0, 1);
    step("R4", 0, 1, 0, 1);
    chk("R4", "tmo_flag cleared", int'(tmo_flag_o), 0);
    idle("R8", 256, 1);
    chk("R8", "period exact", int'(tmo_flag_o), 1);

    // R7 halt, halt between A and B
    step("R7", 0, 0, 1, 1);
    chk("R7", "pdn after halt", int'(pdn_flag_o), 1);
    chk("R7", "tmo after halt", int'(tmo_flag_o), 0);
    idle("R7", 20, 1);
    step("R7", 1, 0, 0, 1);
    step("R7", 0, 0, 1, 1);
    idle("R7", 9, 1);
    step("R7", 0, 1, 0, 1);
    chk("R7", "pending forgotten", int'(wdt_count_o != 0), 1);
    step("R7", 1, 0, 0, 1);
    chk("R4", "pdn cleared by BA", int'(pdn_flag_o), 0);
    step("R7", 0, 1, 0, 1);
    step("R7", 1, 0, 1, 1);
    chk("R7", "halt beats pair", int'(pdn_flag_o), 1);

    // R3 disable holds zero, flags kept, pairing still works
    idle("R3", 30, 1);
    idle("R3", 12, 0);
    chk("R3", "count disabled", int'(wdt_count_o), 0);
    chk("R3", "pdn kept", int'(pdn_flag_o), 1);
    step("R3", 1, 0, 0, 0);
    step("R3", 0, 1, 0, 0);
    chk("R3", "pair while disabled", int'(pdn_flag_o), 0);
    idle("R3", 9, 1);
    chk("R3", "count after re-enable", int'(wdt_count_o), 2);

    finish_run();
  end
endmodule